// File: doc/BRIEF.md
# Coefficient Safeload Engine

This block swaps a group of coefficients in a streaming audio processor's parameter RAM so that the running program never sees a coefficient set that is only partly updated. A host fills a small staging buffer through a simple register write port. It then writes the destination address and arms the update by writing a word count. The block waits for the next audio frame boundary, which arrives as a one-cycle tick. It then copies the staged words into parameter RAM, one word per clock on back-to-back cycles, so the whole update falls between two frames.

The destination register holds the real RAM address minus one. The engine adds that one back before it writes. Words pass through unchanged. The first payload byte sits in bits 31:24, so a payload is big-endian within each word. A payload that ends part-way through a word is zero-padded by the host, and the padded word is counted. The staging words and the destination stay in place after a transfer, so writing the trigger again replays the same update.

Top module: `coef_safeload_engine`

## Requirements
- R1: Host address map. Addresses 1 to 5 write staging words 0 to 4. Address 6 writes the stored destination value, which is the target address minus one. Address 7 is the trigger, and its full 32-bit data is the word count.
- R2: A trigger whose count is 1 to 5, written while idle, arms the engine. `busy` reads 1 from the clock edge that captures that write.
- R3: A trigger count of 0, or of more than 5, is ignored. `busy` stays 0, and a later frame tick causes no RAM write.
- R4: An armed engine does not write until a frame tick arrives in a later cycle. A tick in the same cycle as the trigger write does not start the copy.
- R5: The copy starts in the cycle after the edge that samples the tick. It makes exactly `count` writes, one per cycle with no gap, and `ram_we` does not rise at any other time.
- R6: Write i (i = 0 to count-1) goes to address stored+1+i, taken modulo 2^RAM_AW.
- R7: Write i carries staging word i exactly as the host wrote it, with bit 31:24 as the first payload byte.
- R8: `busy` falls in the cycle after the last write. `ram_we` is never 1 while `busy` is 0.
- R9: Every host write is dropped while `busy` is 1. This covers staging, destination and trigger.
- R10: Staging words and the destination persist after a transfer, so a trigger write alone repeats the update.
- R11: After reset, `busy` and `ram_we` are 0, and all staging words and the destination read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | HOST_AW (4) | Host register address |
| host_wdata | input | DATA_W (32) | Host write data |
| host_we | input | 1 | Host write strobe, one write per cycle |
| frame_tick | input | 1 | Audio frame boundary pulse |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | RAM_AW (12) | Parameter RAM word address |
| ram_wdata | output | DATA_W (32) | Parameter RAM write data |
| busy | output | 1 | High from arming until the last word is written |

## Verification
The assertions assume three things about the inputs. Reset is held low for at least one edge before operation. `host_addr` and `host_wdata` carry known values whenever `host_we` is high. `frame_tick` may arrive in any cycle, including while idle or in the middle of a copy. The stimulus holds reset for several cycles and drives every input to a known level on falling edges. Ticks are sent as one-cycle pulses at random distances from the trigger. Random counts stay within 1 to 5. Illegal counts, a tick that coincides with the trigger, address wrap-around and host writes made while busy are exercised as directed cases.

// File: rtl/sl_pkg.sv
// Shared types and helpers for the coefficient safeload engine.
// Assumes: nothing beyond the parameters handed to its functions.
package sl_pkg;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_ARMED = 2'd1,
        SL_COPY  = 2'd2
    } sl_state_e;

    // True when a trigger value is a usable word count.
    function automatic logic count_ok(input logic [31:0] value, input int unsigned slots);
        return (value != 32'd0) && (value <= 32'(slots));
    endfunction

endpackage

// File: rtl/sl_stage_regs.sv
// Host-facing register file: staging words, stored destination and the trigger decode.
// Assumes: one host write per cycle. Any write is dropped while busy is high.
module sl_stage_regs #(
    parameter int HOST_AW = 4,
    parameter int DATA_W  = 32,
    parameter int RAM_AW  = 12,
    parameter int SLOTS   = 5,
    parameter int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [HOST_AW-1:0]             host_addr,
    input  logic [DATA_W-1:0]              host_wdata,
    input  logic                           host_we,
    input  logic                           busy,
    output logic [SLOTS-1:0][DATA_W-1:0]   slot_q,
    output logic [RAM_AW-1:0]              dest_q,
    output logic                           trig_fire,
    output logic [CNT_W-1:0]               trig_cnt
);
    import sl_pkg::*;

    localparam logic [HOST_AW-1:0] DEST_ADDR = HOST_AW'(SLOTS + 1);
    localparam logic [HOST_AW-1:0] TRIG_ADDR = HOST_AW'(SLOTS + 2);

    logic wr_ok;
    assign wr_ok = host_we && !busy;

    // One register per staging word, each with its own address decode.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic slot_hit;
        assign slot_hit = wr_ok && (host_addr == HOST_AW'(s + 1));

        // Capture the staging word when the host addresses this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)        slot_q[s] <= '0;
            else if (slot_hit) slot_q[s] <= host_wdata;
        end

        // R9
        stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(busy) |-> $stable(slot_q[s]));
    end

    // Capture the stored destination value (target minus one).
    always_ff @(posedge clk) begin
        if (!rst_n)                                  dest_q <= '0;
        else if (wr_ok && host_addr == DEST_ADDR)    dest_q <= host_wdata[RAM_AW-1:0];
    end

    // Decode a trigger write carrying a legal count.
    always_comb begin
        trig_fire = wr_ok && (host_addr == TRIG_ADDR) && count_ok(host_wdata, SLOTS);
        trig_cnt  = host_wdata[CNT_W-1:0];
    end

    // R9
    dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(dest_q));

endmodule

// File: rtl/sl_sequencer.sv
// Arm / wait-for-frame / copy state machine with the word index.
// Assumes: trig_fire is asserted only while idle, with a count of 1..SLOTS.
module sl_sequencer #(
    parameter int SLOTS = 5,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fire,
    input  logic [CNT_W-1:0] trig_cnt,
    input  logic             frame_tick,
    output logic             busy,
    output logic             copying,
    output logic [CNT_W-1:0] idx
);
    import sl_pkg::*;

    sl_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             last_word;

    assign last_word = (idx_q == cnt_q - CNT_W'(1));

    // Advance through arm, wait and copy; count words during the copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SL_IDLE: if (trig_fire) begin
                    state_q <= SL_ARMED;
                    cnt_q   <= trig_cnt;
                end
                SL_ARMED: if (frame_tick) begin
                    state_q <= SL_COPY;
                    idx_q   <= '0;
                end
                SL_COPY: begin
                    if (last_word) state_q <= SL_IDLE;
                    else           idx_q   <= idx_q + CNT_W'(1);
                end
                default: state_q <= SL_IDLE;
            endcase
        end
    end

    // Present status to the rest of the block.
    always_comb begin
        busy    = (state_q != SL_IDLE);
        copying = (state_q == SL_COPY);
        idx     = idx_q;
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0) && (cnt_q <= CNT_W'(SLOTS)));

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copying |-> (idx_q < cnt_q));

    // R4
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_ARMED && !frame_tick) |=> (state_q == SL_ARMED));

endmodule

// File: rtl/sl_ram_port.sv
// Forms the parameter-RAM write: adds the bias back onto the destination and picks the word.
// Assumes: idx stays below SLOTS while copying is high.
module sl_ram_port #(
    parameter int DATA_W = 32,
    parameter int RAM_AW = 12,
    parameter int SLOTS  = 5,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                         copying,
    input  logic [CNT_W-1:0]             idx,
    input  logic [SLOTS-1:0][DATA_W-1:0] slot_q,
    input  logic [RAM_AW-1:0]            dest_q,
    output logic                         ram_we,
    output logic [RAM_AW-1:0]            ram_addr,
    output logic [DATA_W-1:0]            ram_wdata
);
    // Drive the write port straight from the sequencer state.
    always_comb begin
        ram_we    = copying;
        ram_addr  = dest_q + RAM_AW'(1) + RAM_AW'(idx);
        ram_wdata = '0;
        if (idx < CNT_W'(SLOTS)) ram_wdata = slot_q[idx];
    end
endmodule

// File: rtl/coef_safeload_engine.sv
// Top level of the coefficient safeload engine: host registers, sequencer and RAM port.
// Assumes: frame_tick is synchronous to clk; the RAM accepts one write per cycle.
module coef_safeload_engine #(
    parameter int HOST_AW = 4,
    parameter int DATA_W  = 32,
    parameter int RAM_AW  = 12,
    parameter int SLOTS   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_we,
    input  logic               frame_tick,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    output logic               busy
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0][DATA_W-1:0] slot_q;
    logic [RAM_AW-1:0]            dest_q;
    logic                         trig_fire;
    logic [CNT_W-1:0]             trig_cnt;
    logic                         copying;
    logic [CNT_W-1:0]             idx;

    sl_stage_regs #(
        .HOST_AW(HOST_AW), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .SLOTS(SLOTS), .CNT_W(CNT_W)
    ) stage_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .busy(busy), .slot_q(slot_q), .dest_q(dest_q),
        .trig_fire(trig_fire), .trig_cnt(trig_cnt)
    );

    sl_sequencer #(.SLOTS(SLOTS), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .trig_fire(trig_fire), .trig_cnt(trig_cnt),
        .frame_tick(frame_tick), .busy(busy), .copying(copying), .idx(idx)
    );

    sl_ram_port #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .SLOTS(SLOTS), .CNT_W(CNT_W)) ram_i (
        .copying(copying), .idx(idx), .slot_q(slot_q), .dest_q(dest_q),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // R5
    tick_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> $past(frame_tick));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + RAM_AW'(1)));

    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    // R2
    arm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_we));

endmodule

// File: tb/coef_safeload_engine_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random transfers.
module coef_safeload_engine_tb_top;
    localparam int HOST_AW = 4;
    localparam int DATA_W  = 32;
    localparam int RAM_AW  = 12;
    localparam int SLOTS   = 5;
    localparam logic [31:0] AMASK = (32'd1 << RAM_AW) - 32'd1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [DATA_W-1:0]  host_wdata = '0;
    logic               host_we = 1'b0;
    logic               frame_tick = 1'b0;
    logic               ram_we;
    logic [RAM_AW-1:0]  ram_addr;
    logic [DATA_W-1:0]  ram_wdata;
    logic               busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] exp_w [SLOTS];
    logic [31:0] exp_dest;

    always #10 clk = ~clk;

    coef_safeload_engine #(
        .HOST_AW(HOST_AW), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .SLOTS(SLOTS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .frame_tick(frame_tick), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy)
    );

    // Ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_addr(input logic [31:0] dest, input int i);
        return (dest + 32'd1 + 32'(i)) & AMASK;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_addr = HOST_AW'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    // Idle cycles in which no RAM write may appear.
    task automatic quiet(input int n, input string req, input logic exp_busy);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({req, " no write"}, 32'(ram_we), 32'd0);
            chk({req, " busy"}, 32'(busy), 32'(exp_busy));
        end
    endtask

    // Called right after the tick edge; checks every word and the end of busy.
    task automatic expect_copy(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk({req, " R5 we"}, 32'(ram_we), 32'd1);
            chk({req, " R6 addr"}, 32'(ram_addr), exp_addr(exp_dest, i));
            chk({req, " R7 data"}, ram_wdata, exp_w[i]);
        end
        @(negedge clk);
        chk({req, " R8 we off"}, 32'(ram_we), 32'd0);
        chk({req, " R8 busy off"}, 32'(busy), 32'd0);
    endtask

    task automatic load(input int n, input int cnt);
        for (int i = 0; i < n; i++) host_wr(i + 1, exp_w[i]);
        host_wr(SLOTS + 1, exp_dest);
        host_wr(SLOTS + 2, 32'(cnt));
    endtask

    initial begin
        void'($urandom(32'h5AFE_1001));
        for (int i = 0; i < SLOTS; i++) exp_w[i] = '0;
        exp_dest = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 we", 32'(ram_we), 32'd0);

        // R11 R10: trigger alone after reset replays zero staging to address 1
        host_wr(SLOTS + 2, 32'd2);
        chk("R2 busy after trigger", 32'(busy), 32'd1);
        tick();
        expect_copy(2, "R11");

        // R1 R4 R9: full five-word load, wait, busy-time writes dropped
        exp_w[0] = 32'h1122_3344; exp_w[1] = 32'h5566_7788; exp_w[2] = 32'h99AA_BBCC;
        exp_w[3] = 32'hDDEE_FF00; exp_w[4] = 32'h0BAD_F00D; exp_dest = 32'h0FF;
        load(5, 5);
        chk("R2 armed", 32'(busy), 32'd1);
        host_wr(1, 32'hDEAD_BEEF);
        host_wr(SLOTS + 1, 32'h0123);
        host_wr(SLOTS + 2, 32'd1);
        quiet(3, "R4 R9", 1'b1);
        tick();
        expect_copy(5, "R1 R9");

        // R10: replay of three words without rewriting anything
        host_wr(SLOTS + 2, 32'd3);
        tick();
        expect_copy(3, "R10");

        // R3: illegal counts
        host_wr(SLOTS + 2, 32'd0);
        chk("R3 count 0", 32'(busy), 32'd0);
        host_wr(SLOTS + 2, 32'd6);
        chk("R3 count 6", 32'(busy), 32'd0);
        host_wr(SLOTS + 2, 32'h0000_0103);
        chk("R3 count 0x103", 32'(busy), 32'd0);
        tick();
        quiet(3, "R3", 1'b0);

        // R6: destination wraps across the top of RAM
        exp_dest = 32'hFFE;
        load(0, 3);
        tick();
        expect_copy(3, "R6 wrap");

        // R4: tick in the same cycle as the trigger is ignored
        exp_dest = 32'h200;
        @(negedge clk);
        host_addr = HOST_AW'(SLOTS + 1); host_wdata = exp_dest; host_we = 1'b1;
        @(negedge clk);
        host_addr = HOST_AW'(SLOTS + 2); host_wdata = 32'd2; frame_tick = 1'b1;
        @(negedge clk);
        host_we = 1'b0; frame_tick = 1'b0;
        chk("R4 coincident busy", 32'(busy), 32'd1);
        quiet(2, "R4 coincident", 1'b1);
        tick();
        expect_copy(2, "R4");

        // R7: padded tail word passes through, first byte in bits 31:24
        exp_w[0] = 32'hA1B2_C300; exp_dest = 32'h040;
        load(1, 1);
        tick();
        expect_copy(1, "R7 padded");

        // Random transfers
        for (int it = 0; it < 30; it++) begin
            int n;
            int dly;
            n = $urandom_range(1, SLOTS);
            dly = $urandom_range(0, 4);
            for (int i = 0; i < n; i++) exp_w[i] = $urandom;
            exp_dest = $urandom & AMASK;
            load(n, n);
            if ($urandom_range(0, 1) == 1) host_wr($urandom_range(1, SLOTS + 2), $urandom);
            quiet(dly, "R4 random", 1'b1);
            tick();
            expect_copy(n, "R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule